// File: doc/BRIEF.md
# Single-Precision to Signed Integer Converter

This block turns one IEEE-754 single-precision operand into a signed integer of either 32 or 64 bits. The caller picks a fixed rounding direction (toward zero, toward minus infinity, toward plus infinity, nearest with ties to even), or asks the block to follow the rounding mode currently held in the low two bits of the floating-point control register. The result comes out on a 64-bit bus one clock after the request. A 32-bit result is sign-extended to fill the bus.

Next to the result the block raises four exception set-pulses: invalid, inexact, underflow and overflow. Each pulse lasts one cycle and travels with its result. The caller ORs the pulses into its own sticky status register. Clearing that register is not part of this block. Some results cannot be represented: a NaN, an infinity, or a rounded value outside the chosen integer range. For these the block replaces the converted value with a fixed saturation pattern. An out-of-range result always raises invalid together with overflow.

Top module: `f2i_convert`

## Requirements
- R1: A request accepted with `in_valid` high produces `res_valid` high with its result and flags exactly one clock later. Back-to-back requests are accepted every cycle. While `res_valid` is low, all four flag outputs are low.
- R2: `in_op` values 0, 1 and 2 round toward zero, toward minus infinity and toward plus infinity respectively.
- R3: `in_op` value 3 rounds to the nearest integer, and an exact halfway value goes to the even neighbour.
- R4: `in_op` values 4 to 7 take the direction from `csr_mode` (0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity). For `in_op` 0 to 3, `csr_mode` has no effect on the result.
- R5: With `in_wide` = 0 the result is a signed 32-bit value, sign-extended into `res_data[63:32]`. With `in_wide` = 1 it is a signed 64-bit value.
- R6: `flg_inexact` pulses exactly when a finite operand has a nonzero fractional part, that is, when the rounded integer differs from the operand.
- R7: A NaN operand (exponent all ones, nonzero fraction) pulses `flg_invalid` only. An infinity pulses both `flg_invalid` and `flg_overflow`.
- R8: A finite rounded value above 2^(N-1)-1 or below -2^(N-1) for the chosen width N pulses both `flg_overflow` and `flg_invalid`. The value -2^(N-1) itself is in range.
- R9: Every invalid result is replaced by a saturation pattern: 0x000000007FFFFFFF for 32-bit results, 0x7FFFFFFFFFFFFFFF for 64-bit results.
- R10: `flg_underflow` pulses only for a nonzero rounded result whose magnitude is below the smallest normal single-precision value. A nonzero integer is never that small, so the pulse stays low. Subnormal operands round to 0 or ±1 and raise only inexact.
- R11: After reset, `res_valid` and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 32 | Single-precision operand bits |
| in_op | input | 3 | Operation select (see R2-R4) |
| in_wide | input | 1 | 0 = 32-bit result, 1 = 64-bit result |
| csr_mode | input | 2 | Rounding mode bits from the control register |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 64 | Signed integer result or saturation pattern |
| flg_invalid | output | 1 | Invalid-operation set-pulse |
| flg_inexact | output | 1 | Inexact set-pulse |
| flg_underflow | output | 1 | Underflow set-pulse |
| flg_overflow | output | 1 | Overflow set-pulse |

## Verification
The internal state is one result register, so every fault shows at the ports on the cycle right after the request. Typical faults and how they appear:
- A wrong shift position shows as a result off by a power of two.
- A wrong round-up decision shows as an off-by-one value near halfway points, or on the wrong side of zero.
- A wrong range limit shows as a missing overflow or a spurious overflow at ±2^31 and ±2^63.
- A stale or misrouted width select shows as a 32-bit result that is not sign-extended, or as the wrong saturation pattern.

The stimulus mixes random operands, whose exponents are centred on the fractional and overflow zones, with directed halfway, boundary, subnormal and special values. Each result is compared with a real-number model in the cycle it appears.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    // Source format
    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int BIAS     = 127;
    localparam int SIG_W    = MAN_W + 1;
    // Result formats
    localparam int INT_W    = 64;
    localparam int NARROW_W = 32;
    localparam int EW2      = EXP_W + 2;

    typedef enum logic [1:0] {
        DIR_NEAR = 2'd0,
        DIR_ZERO = 2'd1,
        DIR_UP   = 2'd2,
        DIR_DOWN = 2'd3
    } rdir_e;

    // Unpacked operand in fixed point: integer part, half bit, rest.
    typedef struct packed {
        logic             neg;
        logic             is_nan;
        logic             is_inf;
        logic             huge;
        logic [INT_W-1:0] mag;
        logic             guard;
        logic             sticky;
    } fix_t;

    typedef struct packed {
        logic             valid;
        logic             wide;
        logic [INT_W-1:0] data;
        logic             inv;
        logic             inx;
        logic             unf;
        logic             ovf;
    } res_t;

    function automatic rdir_e pick_dir(input logic [2:0] op, input logic [1:0] mode);
        rdir_e d;
        case (op)
            3'd0:    d = DIR_ZERO;
            3'd1:    d = DIR_DOWN;
            3'd2:    d = DIR_UP;
            3'd3:    d = DIR_NEAR;
            default: d = rdir_e'(mode);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] op_bits,
    output fix_t            fx
);
    localparam int X_W  = INT_W + SIG_W;
    localparam int SH_W = $clog2(INT_W + 1);
    localparam logic signed [EW2-1:0] E_HUGE = EW2'(INT_W);
    localparam logic signed [EW2-1:0] E_LOW  = -EW2'(1);
    localparam logic signed [EW2-1:0] E_BIAS = EW2'(BIAS);

    logic [EXP_W-1:0]        exp_f;
    logic [MAN_W-1:0]        man_f;
    logic signed [EW2-1:0]   e_unb;
    logic signed [EW2-1:0]   e_sh;
    logic [SH_W-1:0]         sh;
    logic [X_W-1:0]          xs;

    always_comb begin
        exp_f = op_bits[FP_W-2 -: EXP_W];
        man_f = op_bits[MAN_W-1:0];
        e_unb = signed'({2'b00, exp_f}) - E_BIAS;
        e_sh  = e_unb + EW2'(1);
        sh    = '0;
        xs    = '0;
        fx        = '0;
        fx.neg    = op_bits[FP_W-1];
        if (exp_f == '1) begin
            fx.is_nan = (man_f != '0);
            fx.is_inf = (man_f == '0);
        end else if (exp_f == '0) begin
            // zero or subnormal: below one half, fraction only
            fx.sticky = (man_f != '0);
        end else if (e_unb >= E_HUGE) begin
            fx.huge = 1'b1;
        end else if (e_unb < E_LOW) begin
            fx.sticky = 1'b1;
        end else begin
            // value * 2^SIG_W = significand * 2^(e+1)
            sh        = SH_W'(e_sh);
            xs        = X_W'({1'b1, man_f}) << sh;
            fx.mag    = xs[X_W-1 -: INT_W];
            fx.guard  = xs[SIG_W-1];
            fx.sticky = |xs[SIG_W-2:0];
        end
    end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic [INT_W-1:0] mag,
    input  logic             guard,
    input  logic             sticky,
    input  logic             neg,
    input  rdir_e            dir,
    output logic [INT_W:0]   mag_r
);
    logic frac;
    logic inc;

    always_comb begin
        frac = guard | sticky;
        case (dir)
            DIR_NEAR: inc = guard & (sticky | mag[0]);
            DIR_UP:   inc = ~neg & frac;
            DIR_DOWN: inc = neg & frac;
            default:  inc = 1'b0;
        endcase
        mag_r = {1'b0, mag} + {{INT_W{1'b0}}, inc};
    end

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
    import f2i_pkg::*;
(
    input  logic [INT_W:0]   mag_r,
    input  logic             neg,
    input  logic             is_nan,
    input  logic             is_inf,
    input  logic             huge,
    input  logic             guard,
    input  logic             sticky,
    input  logic             wide,
    output logic [INT_W-1:0] data,
    output logic             inv,
    output logic             inx,
    output logic             unf,
    output logic             ovf
);
    localparam logic [INT_W:0]   HALF_W = (INT_W+1)'(1) << (INT_W - 1);
    localparam logic [INT_W:0]   HALF_N = (INT_W+1)'(1) << (NARROW_W - 1);
    localparam logic [INT_W-1:0] SAT_W  = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_N  = INT_W'({1'b0, {(NARROW_W-1){1'b1}}});

    logic [INT_W:0]   half;
    logic             oor;
    logic             special;
    logic [INT_W-1:0] sval;
    logic [INT_W-1:0] val;

    always_comb begin
        half    = wide ? HALF_W : HALF_N;
        oor     = huge | (neg ? (mag_r > half) : (mag_r >= half));
        special = is_nan | is_inf;
        sval    = neg ? (~mag_r[INT_W-1:0] + INT_W'(1)) : mag_r[INT_W-1:0];
        if (wide) begin
            val = sval;
        end else begin
            val = {{(INT_W-NARROW_W){sval[NARROW_W-1]}}, sval[NARROW_W-1:0]};
        end
        inv  = special | oor;
        ovf  = is_inf | oor;
        inx  = ~special & (guard | sticky);
        // a rounded nonzero integer has magnitude >= 1, far above the
        // smallest normal single, so this pulse cannot be produced here
        unf  = 1'b0;
        data = inv ? (wide ? SAT_W : SAT_N) : val;
    end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_operand,
    input  logic [2:0]       in_op,
    input  logic             in_wide,
    input  logic [1:0]       csr_mode,
    output logic             res_valid,
    output logic [INT_W-1:0] res_data,
    output logic             flg_invalid,
    output logic             flg_inexact,
    output logic             flg_underflow,
    output logic             flg_overflow
);
    localparam logic [INT_W-1:0] SAT_W = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_N = INT_W'({1'b0, {(NARROW_W-1){1'b1}}});

    fix_t             fx;
    rdir_e            dir;
    logic [INT_W:0]   mag_r;
    logic [INT_W-1:0] p_data;
    logic             p_inv, p_inx, p_unf, p_ovf;
    res_t             st_d, st_q;

    assign dir = pick_dir(in_op, csr_mode);

    f2i_unpack u_unpack (
        .op_bits (in_operand),
        .fx      (fx)
    );

    f2i_round u_round (
        .mag    (fx.mag),
        .guard  (fx.guard),
        .sticky (fx.sticky),
        .neg    (fx.neg),
        .dir    (dir),
        .mag_r  (mag_r)
    );

    f2i_pack u_pack (
        .mag_r  (mag_r),
        .neg    (fx.neg),
        .is_nan (fx.is_nan),
        .is_inf (fx.is_inf),
        .huge   (fx.huge),
        .guard  (fx.guard),
        .sticky (fx.sticky),
        .wide   (in_wide),
        .data   (p_data),
        .inv    (p_inv),
        .inx    (p_inx),
        .unf    (p_unf),
        .ovf    (p_ovf)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.valid = 1'b1;
            st_d.wide  = in_wide;
            st_d.data  = p_data;
            st_d.inv   = p_inv;
            st_d.inx   = p_inx;
            st_d.unf   = p_unf;
            st_d.ovf   = p_ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid     = st_q.valid;
    assign res_data      = st_q.data;
    assign flg_invalid   = st_q.inv;
    assign flg_inexact   = st_q.inx;
    assign flg_underflow = st_q.unf;
    assign flg_overflow  = st_q.ovf;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    a_r1_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(flg_invalid | flg_inexact | flg_underflow | flg_overflow));

    a_r8_ovf_with_inv: assert property (@(posedge clk) disable iff (!rst_n)
        flg_overflow |-> flg_invalid);

    a_r6_inexact_finite: assert property (@(posedge clk) disable iff (!rst_n)
        flg_inexact |-> !flg_invalid);

    a_r9_sat_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flg_invalid && !st_q.wide) |-> (res_data == SAT_N));

    a_r9_sat_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flg_invalid && st_q.wide) |-> (res_data == SAT_W));

    a_r5_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !st_q.wide) |-> (res_data[INT_W-1:NARROW_W] == {(INT_W-NARROW_W){res_data[NARROW_W-1]}}));

endmodule

// File: tb/f2i_convert_tb.sv
`timescale 1ns/1ps
module f2i_convert_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic [2:0]  in_op = '0;
    logic        in_wide = 1'b0;
    logic [1:0]  csr_mode = '0;
    logic        res_valid;
    logic [63:0] res_data;
    logic        flg_invalid, flg_inexact, flg_underflow, flg_overflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expectation for the request currently in flight
    logic        e_valid = 1'b0;
    logic [63:0] e_data;
    logic        e_inv, e_inx, e_unf, e_ovf;
    string       e_tag = "";

    always #2.5 clk = ~clk;

    f2i_convert u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_operand    (in_operand),
        .in_op         (in_op),
        .in_wide       (in_wide),
        .csr_mode      (csr_mode),
        .res_valid     (res_valid),
        .res_data      (res_data),
        .flg_invalid   (flg_invalid),
        .flg_inexact   (flg_inexact),
        .flg_underflow (flg_underflow),
        .flg_overflow  (flg_overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", tag, act, exp);
        end
    endtask

    function automatic real pow2(input int e);
        real p = 1.0;
        if (e >= 0) for (int i = 0; i < e; i++) p = p * 2.0;
        else        for (int i = 0; i < -e; i++) p = p / 2.0;
        return p;
    endfunction

    function automatic real bits2real(input logic [31:0] b);
        real m;
        int  e;
        if (b[30:23] == 8'd0) begin
            m = real'(b[22:0]);
            e = -149;
        end else begin
            m = real'(b[22:0]) + 8388608.0;
            e = int'(b[30:23]) - 150;
        end
        return b[31] ? -(m * pow2(e)) : m * pow2(e);
    endfunction

    // expected values from the requirements
    task automatic model(input logic [2:0] op, input logic wide, input logic [1:0] md,
                         input logic [31:0] b);
        int  dir;  // 0 nearest, 1 zero, 2 up, 3 down
        real v, fl, rr, lim;
        logic [63:0] sat;
        sat   = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        e_unf = 1'b0;
        if (b[30:23] == 8'hFF) begin
            e_inv  = 1'b1;
            e_inx  = 1'b0;
            e_ovf  = (b[22:0] == 23'd0);
            e_data = sat;
            return;
        end
        case (op)
            3'd0: dir = 1;
            3'd1: dir = 3;
            3'd2: dir = 2;
            3'd3: dir = 0;
            default: dir = int'(md);
        endcase
        v  = bits2real(b);
        fl = $floor(v);
        case (dir)
            1: rr = (v >= 0.0) ? $floor(v) : $ceil(v);
            2: rr = $ceil(v);
            3: rr = fl;
            default: begin
                if (v - fl > 0.5)      rr = fl + 1.0;
                else if (v - fl < 0.5) rr = fl;
                else if ($floor(fl / 2.0) == fl / 2.0) rr = fl;
                else rr = fl + 1.0;
            end
        endcase
        lim   = wide ? pow2(63) : pow2(31);
        e_inx = (rr != v);
        e_ovf = (rr >= lim) || (rr < -lim);
        e_inv = e_ovf;
        e_data = e_ovf ? sat : 64'(longint'(rr));
    endtask

    task automatic compare();
        if (e_valid) begin
            chk("R1 valid", 64'(res_valid), 64'd1);
            chk(e_tag, res_data, e_data);
            chk("R7/R8 invalid", 64'(flg_invalid), 64'(e_inv));
            chk("R6 inexact", 64'(flg_inexact), 64'(e_inx));
            chk("R10 underflow", 64'(flg_underflow), 64'(e_unf));
            chk("R8 overflow", 64'(flg_overflow), 64'(e_ovf));
        end else begin
            chk("R1 idle valid", 64'(res_valid), 64'd0);
            chk("R1 idle flags", {60'd0, flg_invalid, flg_inexact, flg_underflow, flg_overflow}, 64'd0);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic wide,
                        input logic [1:0] md, input logic [31:0] b, input string tag);
        @(negedge clk);
        compare();
        in_valid   = v;
        in_op      = op;
        in_wide    = wide;
        csr_mode   = md;
        in_operand = b;
        e_valid    = v;
        e_tag      = tag;
        if (v) model(op, wide, md, b);
    endtask

    task automatic one(input logic [2:0] op, input logic wide, input logic [1:0] md,
                       input logic [31:0] b, input string tag);
        step(1'b1, op, wide, md, b, tag);
        step(1'b0, 3'd0, 1'b0, 2'd0, 32'd0, "R1");
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int sd;
        sd = int'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 reset valid", 64'(res_valid), 64'd0);
        chk("R11 reset flags", {60'd0, flg_invalid, flg_inexact, flg_underflow, flg_overflow}, 64'd0);

        // R2 fixed directions
        one(3'd0, 1'b1, 2'd0, 32'h4030_0000, "R2 trunc 2.75");
        one(3'd0, 1'b1, 2'd0, 32'hC030_0000, "R2 trunc -2.75");
        one(3'd1, 1'b1, 2'd0, 32'h4030_0000, "R2 floor 2.75");
        one(3'd1, 1'b1, 2'd0, 32'hC030_0000, "R2 floor -2.75");
        one(3'd2, 1'b1, 2'd0, 32'h4030_0000, "R2 ceil 2.75");
        one(3'd2, 1'b1, 2'd0, 32'hC030_0000, "R2 ceil -2.75");
        one(3'd2, 1'b0, 2'd0, 32'hBF00_0000, "R2 ceil -0.5");
        // R3 ties to even
        one(3'd3, 1'b1, 2'd0, 32'h4020_0000, "R3 near 2.5");
        one(3'd3, 1'b1, 2'd0, 32'h4060_0000, "R3 near 3.5");
        one(3'd3, 1'b0, 2'd0, 32'hC020_0000, "R3 near -2.5");
        one(3'd3, 1'b0, 2'd0, 32'hBFC0_0000, "R3 near -1.5");
        one(3'd3, 1'b0, 2'd0, 32'h3F00_0000, "R3 near 0.5");
        one(3'd3, 1'b0, 2'd0, 32'h4030_0000, "R3 near 2.75");
        // R4 mode driven and mode ignored
        one(3'd4, 1'b1, 2'd0, 32'h4020_0000, "R4 csr nearest 2.5");
        one(3'd4, 1'b1, 2'd1, 32'hC030_0000, "R4 csr zero -2.75");
        one(3'd4, 1'b1, 2'd2, 32'h4010_0000, "R4 csr up 2.25");
        one(3'd4, 1'b1, 2'd3, 32'h4010_0000, "R4 csr down 2.25");
        one(3'd7, 1'b1, 2'd2, 32'h4010_0000, "R4 op7 csr up 2.25");
        one(3'd3, 1'b1, 2'd1, 32'h4020_0000, "R4 near ignores mode");
        one(3'd0, 1'b1, 2'd2, 32'h4010_0000, "R4 trunc ignores mode");
        // R5 widths
        one(3'd0, 1'b0, 2'd0, 32'hC0A0_0000, "R5 narrow -5");
        one(3'd0, 1'b1, 2'd0, 32'hC0A0_0000, "R5 wide -5");
        one(3'd2, 1'b0, 2'd0, 32'h4EFF_FFFF, "R5 narrow max float below 2^31");
        // R8 / R9 range edges
        one(3'd0, 1'b0, 2'd0, 32'h4F00_0000, "R9 narrow 2^31 saturates");
        one(3'd0, 1'b0, 2'd0, 32'hCF00_0000, "R8 narrow -2^31 in range");
        one(3'd0, 1'b1, 2'd0, 32'h4F00_0000, "R8 wide 2^31 in range");
        one(3'd1, 1'b1, 2'd0, 32'h5F00_0000, "R9 wide 2^63 saturates");
        one(3'd1, 1'b1, 2'd0, 32'hDF00_0000, "R8 wide -2^63 in range");
        one(3'd1, 1'b1, 2'd0, 32'hDF00_0001, "R9 wide below -2^63");
        // R7 specials
        one(3'd0, 1'b0, 2'd0, 32'h7FC0_0000, "R7 nan narrow");
        one(3'd3, 1'b1, 2'd0, 32'hFFC0_0001, "R7 nan wide");
        one(3'd0, 1'b0, 2'd0, 32'h7F80_0000, "R7 +inf narrow");
        one(3'd2, 1'b1, 2'd0, 32'hFF80_0000, "R7 -inf wide");
        // R10 subnormals and zeros, R6 exact
        one(3'd2, 1'b0, 2'd0, 32'h0000_0001, "R10 ceil +subnormal");
        one(3'd1, 1'b1, 2'd0, 32'h8000_0001, "R10 floor -subnormal");
        one(3'd0, 1'b0, 2'd0, 32'h0000_0001, "R10 trunc subnormal");
        one(3'd1, 1'b0, 2'd0, 32'h8000_0000, "R10 floor -0");
        one(3'd3, 1'b1, 2'd0, 32'h0000_0000, "R10 near +0");
        one(3'd3, 1'b0, 2'd0, 32'h3F80_0000, "R6 exact 1.0");
        one(3'd3, 1'b0, 2'd0, 32'h3F7F_FFFF, "R6 near 0.99999994");

        // back-to-back random stream (R1 throughput)
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] b;
            logic [2:0]  op;
            string       tg;
            b  = $urandom;
            if ($urandom_range(0, 3) != 0) b[30:23] = 8'(100 + $urandom_range(0, 100));
            op = 3'($urandom_range(0, 7));
            case (op)
                3'd0, 3'd1, 3'd2: tg = "R2 random";
                3'd3:             tg = "R3 random";
                default:          tg = "R4 random";
            endcase
            step(1'b1, op, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), b, tg);
            if ($urandom_range(0, 15) == 0) step(1'b0, 3'd0, 1'b0, 2'd0, 32'd0, "R1");
        end
        step(1'b0, 3'd0, 1'b0, 2'd0, 32'd0, "R1");
        step(1'b0, 3'd0, 1'b0, 2'd0, 32'd0, "R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule